// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word-address stream and the timing of the data and stall indications for a synchronous burst read from a word-organized memory array. A start pulse captures a start address, a 3-bit length code, a linear/wrap control bit and a first-access latency count. The block then holds its stall output high for the latency, and after that presents one word address per clock. Bursts of 4, 8 or 16 words can either wrap inside their aligned block or run straight across it. A continuous mode always counts linearly and stops at the top of the address space.

When a linear burst first steps from the last word of a 16-word row into the next row, the block pauses the burst. The number of stall cycles depends on where the start address sits inside its 4-word group and on the latency count. This happens at most once per burst. A behavioural array stub returns each address as the data word. An edge-select input moves the outputs from the rising edge of the clock to the following falling edge.

Top module: `burst_seq`

## Requirements
- R1: While reset is held low and after it, with no burst started, `word_valid_o` = 0, `hold_o` = 0 and `addr_o` = 0.
- R2: After the rising edge that samples `start_i` = 1 with a valid length code, `hold_o` = 1 and `word_valid_o` = 0 for Leff cycles, where Leff = `latency_i` (0 is treated as 1). In the next cycle `word_valid_o` = 1 and `addr_o` is the start address.
- R3: Length code 3'b001 gives 4 words, 3'b010 gives 8 and 3'b011 gives 16. After the last word, `word_valid_o` = 0 and `hold_o` = 0.
- R4: With `linear_i` = 1, each word address is the previous address + 1, modulo 2^AW.
- R5: With `linear_i` = 0 and a 4-, 8- or 16-word code, the address steps +1 inside the aligned block of the burst length and wraps back to the block base. For example, start 5 with 4 words gives 5, 6, 7, 4.
- R6: Code 3'b111 is continuous. It is linear whatever the value of `linear_i`, and it ends after the word whose address is all ones.
- R7: In a linear or continuous burst, the first time a word whose address has low four bits 4'b1111 is followed by another word, D cycles with `hold_o` = 1 and `word_valid_o` = 0 are inserted before that next word. Let o = start address bits [1:0]. Then D = 0 for o = 0, and D = max(0, Leff + o − 4) otherwise, so D = Leff − 1 for o = 3. No later row crossing in the same burst stalls.
- R8: A new valid start aborts any burst in progress. Address, code, linear bit and latency are captured only at the start, and later changes to them have no effect on the running burst.
- R9: A start with a reserved length code (3'b000, 3'b100, 3'b101 or 3'b110) ends any burst and leaves the block idle (`word_valid_o` = 0, `hold_o` = 0).
- R10: With `negedge_sel_i` = 0 the outputs change on the rising edge. With `negedge_sel_i` = 1 they take the same values half a cycle later, at the following falling edge.
- R11: While `word_valid_o` = 1, `data_o` equals `addr_o` zero-extended to DW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, captures the burst configuration |
| start_addr_i | input | AW | First word address |
| len_code_i | input | 3 | Burst length code |
| linear_i | input | 1 | 1 = no wrapping, 0 = wrap inside the length block |
| negedge_sel_i | input | 1 | 1 = present outputs on the falling edge |
| latency_i | input | LW | First-access latency in cycles |
| addr_o | output | AW | Current word address |
| data_o | output | DW | Array stub data (address) |
| word_valid_o | output | 1 | Data word valid |
| hold_o | output | 1 | Stall indication (latency and row crossing) |

## Verification
The bench builds the block with AW = 8, LW = 4 and DW = 16. With a 256-word space, the rollover of linear fixed bursts and the top-end stop of continuous bursts are both within reach. The bench sweeps every start address in the first two rows, every valid length code, both wrap settings and latencies from 1 to 6. This produces every row-crossing stall length, including zero-length stalls and stalls that follow a start in the last word of a group. Continuous runs are cut off by the next start, which exercises abort. Inputs are scrambled after each start to show that the configuration was captured.

// File: rtl/burst_seq_pkg.sv
// Package: shared types and the length-code decoder for the burst sequencer.
// Assumes: bursts are at most 16 words long, so one row is 16 words.
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LAT   = 2'd1,
        ST_DATA  = 2'd2,
        ST_STALL = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic       ok;     // code is usable
        logic       cont;   // continuous linear burst
        logic [4:0] words;  // fixed burst length (4, 8 or 16)
    } len_dec_t;

    // Decode the 3-bit length code; reserved codes report ok = 0.
    function automatic len_dec_t decode_len(input logic [2:0] code);
        len_dec_t d;
        d = '{ok: 1'b1, cont: 1'b0, words: 5'd16};
        case (code)
            3'b001:  d.words = 5'd4;
            3'b010:  d.words = 5'd8;
            3'b011:  d.words = 5'd16;
            3'b111:  d.cont  = 1'b1;
            default: d.ok    = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/burst_next_addr.sv
// Module: next-word address generator.
// Does: adds one to the address, either linearly or wrapping inside the
// aligned block of the burst length. Assumes AW >= 5 and words in {4,8,16}.
module burst_next_addr #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] addr_i,
    input  logic          wrap_en_i,
    input  logic [4:0]    words_i,
    output logic [AW-1:0] next_o
);
    logic [3:0] mask;
    logic [3:0] low_inc;

    // Form the wrapped or linear successor of the current address.
    always_comb begin
        mask    = 4'(words_i - 5'd1);
        low_inc = addr_i[3:0] + 4'd1;
        if (wrap_en_i)
            next_o = {addr_i[AW-1:4], (addr_i[3:0] & ~mask) | (low_inc & mask)};
        else
            next_o = addr_i + AW'(1);
    end
endmodule

// File: rtl/burst_stall_calc.sv
// Module: row-crossing stall length calculator.
// Does: turns the start offset in its 4-word group and the latency into the
// number of stall cycles. Assumes a latency of 0 behaves as 1.
module burst_stall_calc #(
    parameter int LW = 4
) (
    input  logic [1:0]    offset_i,
    input  logic [LW-1:0] latency_i,
    output logic [LW-1:0] stall_o
);
    logic [LW-1:0] lat_eff;
    logic [LW:0]   sum;

    // Stall = max(0, Leff + offset - 4) for a non-zero offset, else none.
    always_comb begin
        lat_eff = (latency_i == '0) ? LW'(1) : latency_i;
        sum     = {1'b0, lat_eff} + (LW+1)'(offset_i);
        if (offset_i == 2'd0 || sum <= (LW+1)'(4))
            stall_o = '0;
        else
            stall_o = LW'(sum - (LW+1)'(4));
    end
endmodule

// File: rtl/burst_ctrl.sv
// Module: burst sequencing state machine.
// Does: captures a burst on start, counts the latency, steps addresses,
// ends fixed and continuous bursts, and inserts the single row-crossing stall.
// Assumes: start_i is sampled on every rising edge; all state is rising-edge.
module burst_ctrl
    import burst_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [2:0]    len_code_i,
    input  logic          linear_i,
    input  logic [LW-1:0] latency_i,
    output logic [AW-1:0] addr_o,
    output logic          valid_o,
    output logic          hold_o
);
    seq_state_t    state;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] next_addr;
    logic [LW-1:0] lat_cnt;
    logic [LW-1:0] stall_cnt;
    logic [LW-1:0] stall_len_q;
    logic [LW-1:0] stall_len_d;
    logic [4:0]    word_cnt;
    logic [4:0]    words_q;
    logic          cont_q;
    logic          wrap_en_q;
    logic          row_done;
    logic          last_word;
    logic          crossing;
    len_dec_t      dec;

    assign dec = decode_len(len_code_i);

    burst_next_addr #(.AW(AW)) u_next (
        .addr_i    (cur_addr),
        .wrap_en_i (wrap_en_q),
        .words_i   (words_q),
        .next_o    (next_addr)
    );

    burst_stall_calc #(.LW(LW)) u_stall (
        .offset_i  (start_addr_i[1:0]),
        .latency_i (latency_i),
        .stall_o   (stall_len_d)
    );

    // Decide whether the word now shown ends the burst or crosses a row.
    always_comb begin
        last_word = cont_q ? (&cur_addr) : (word_cnt == words_q);
        crossing  = !wrap_en_q && (cur_addr[3:0] == 4'hF) && !row_done
                    && (stall_len_q != '0);
    end

    // Sequencer state, counters and captured configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cur_addr    <= '0;
            lat_cnt     <= '0;
            stall_cnt   <= '0;
            stall_len_q <= '0;
            word_cnt    <= '0;
            words_q     <= 5'd4;
            cont_q      <= 1'b0;
            wrap_en_q   <= 1'b0;
            row_done    <= 1'b0;
        end else if (start_i) begin
            state       <= dec.ok ? ST_LAT : ST_IDLE;
            cur_addr    <= start_addr_i;
            lat_cnt     <= (latency_i == '0) ? '0 : latency_i - LW'(1);
            stall_len_q <= stall_len_d;
            word_cnt    <= 5'd0;
            words_q     <= dec.words;
            cont_q      <= dec.cont;
            wrap_en_q   <= !linear_i && !dec.cont;
            row_done    <= 1'b0;
        end else begin
            case (state)
                ST_LAT: begin
                    if (lat_cnt == '0) begin
                        state    <= ST_DATA;
                        word_cnt <= 5'd1;
                    end else begin
                        lat_cnt <= lat_cnt - LW'(1);
                    end
                end
                ST_DATA: begin
                    if (last_word) begin
                        state <= ST_IDLE;
                    end else if (crossing) begin
                        state     <= ST_STALL;
                        stall_cnt <= stall_len_q - LW'(1);
                        row_done  <= 1'b1;
                    end else begin
                        cur_addr <= next_addr;
                        if (!cont_q) word_cnt <= word_cnt + 5'd1;
                        if (!wrap_en_q && cur_addr[3:0] == 4'hF) row_done <= 1'b1;
                    end
                end
                ST_STALL: begin
                    if (stall_cnt == '0) begin
                        state    <= ST_DATA;
                        cur_addr <= next_addr;
                        if (!cont_q) word_cnt <= word_cnt + 5'd1;
                    end else begin
                        stall_cnt <= stall_cnt - LW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign addr_o  = cur_addr;
    assign valid_o = (state == ST_DATA);
    assign hold_o  = (state == ST_LAT) || (state == ST_STALL);

    // R2: the cycle after the last latency cycle shows the captured start word.
    a_r2_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_LAT && $past(lat_cnt) == '0 && !$past(start_i))
        |-> (state == ST_DATA && $stable(cur_addr)));

    // R3: a fixed burst never shows more words than its length.
    a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !cont_q) |-> (word_cnt != 5'd0 && word_cnt <= words_q));

    // R4: linear bursts step by exactly one between back-to-back words.
    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) == ST_DATA && !$past(start_i) && !wrap_en_q)
        |-> (cur_addr == $past(cur_addr) + AW'(1)));

    // R5: wrapping bursts stay inside their aligned length block.
    a_r5_wrap_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) == ST_DATA && !$past(start_i) && wrap_en_q)
        |-> (cur_addr[AW-1:4] == $past(cur_addr[AW-1:4]) &&
             (((cur_addr[3:0] ^ $past(cur_addr[3:0])) & ~4'(words_q - 5'd1)) == 4'd0)));

    // R6: a continuous burst at the all-ones address does not continue.
    a_r6_cont_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && cont_q && (&cur_addr) && !start_i) |=> (state == ST_IDLE));

    // R7: a stall is entered only from the last word of a row in a linear burst.
    a_r7_stall_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && $past(state) == ST_DATA)
        |-> ($past(cur_addr[3:0]) == 4'hF && !wrap_en_q && !$past(row_done)));

    // R7: stall and valid data never coincide.
    a_r7_hold_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && hold_o));
endmodule

// File: rtl/burst_array_stub.sv
// Module: behavioural array stand-in.
// Does: returns the word address, zero-extended, as the read data.
// Assumes DW >= AW.
module burst_array_stub #(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic [AW-1:0] addr_i,
    output logic [DW-1:0] data_o
);
    // Zero-extend the address into the data word.
    assign data_o = DW'(addr_i);
endmodule

// File: rtl/burst_edge_out.sv
// Module: output edge selector.
// Does: passes rising-edge outputs straight through, or presents them on
// the following falling edge through a falling-edge register stage.
// Assumes the select changes only between bursts.
module burst_edge_out #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         negedge_sel_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] neg_q;

    // Capture the rising-edge result half a cycle later.
    always_ff @(negedge clk) begin
        if (!rst_n) neg_q <= '0;
        else        neg_q <= d_i;
    end

    assign q_o = negedge_sel_i ? neg_q : d_i;
endmodule

// File: rtl/burst_seq.sv
// Module: burst read address sequencer, top level.
// Does: sequences burst addresses, fetches stub data and presents address,
// data, valid and stall on the selected clock edge.
// Assumes AW >= 5, DW >= AW, LW >= 3.
module burst_seq #(
    parameter int AW = 24,
    parameter int DW = 32,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [2:0]    len_code_i,
    input  logic          linear_i,
    input  logic          negedge_sel_i,
    input  logic [LW-1:0] latency_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          word_valid_o,
    output logic          hold_o
);
    localparam int OW = AW + DW + 2;

    logic [AW-1:0] seq_addr;
    logic [DW-1:0] seq_data;
    logic          seq_valid;
    logic          seq_hold;
    logic [OW-1:0] out_bus;

    burst_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .len_code_i   (len_code_i),
        .linear_i     (linear_i),
        .latency_i    (latency_i),
        .addr_o       (seq_addr),
        .valid_o      (seq_valid),
        .hold_o       (seq_hold)
    );

    burst_array_stub #(.AW(AW), .DW(DW)) u_stub (
        .addr_i (seq_addr),
        .data_o (seq_data)
    );

    burst_edge_out #(.W(OW)) u_edge (
        .clk           (clk),
        .rst_n         (rst_n),
        .negedge_sel_i (negedge_sel_i),
        .d_i           ({seq_valid, seq_hold, seq_addr, seq_data}),
        .q_o           (out_bus)
    );

    assign {word_valid_o, hold_o, addr_o, data_o} = out_bus;

    // R11: presented data always mirrors the presented address.
    a_r11_data_match: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (data_o == DW'(addr_o)));
endmodule

// File: tb/burst_seq_tb.sv
`timescale 1ns/100ps
module burst_seq_tb;
    localparam realtime CLK_PERIOD = 10.0;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [2:0]    len_code_i = 3'b001;
    logic          linear_i = 1'b1;
    logic          negedge_sel_i = 1'b0;
    logic [LW-1:0] latency_i = 4'd1;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] data_o;
    logic          word_valid_o;
    logic          hold_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    burst_seq #(.AW(AW), .DW(DW), .LW(LW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .start_addr_i  (start_addr_i),
        .len_code_i    (len_code_i),
        .linear_i      (linear_i),
        .negedge_sel_i (negedge_sel_i),
        .latency_i     (latency_i),
        .addr_o        (addr_o),
        .data_o        (data_o),
        .word_valid_o  (word_valid_o),
        .hold_o        (hold_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one check and report a mismatch.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Sample a quarter period after a falling edge, compare, advance to next falling edge.
    task automatic expect_cyc(input bit v, input bit h, input logic [AW-1:0] a,
                              input bit chk_addr, input string req);
        #(CLK_PERIOD/4);
        if (chk_addr)
            chk(word_valid_o == v && hold_o == h && addr_o == a, req,
                {word_valid_o, hold_o, addr_o}, {v, h, a});
        else
            chk(word_valid_o == v && hold_o == h, req,
                {word_valid_o, hold_o}, {v, h});
        if (v && word_valid_o)
            chk(data_o == DW'(addr_o), "R11", data_o, DW'(addr_o));
        @(negedge clk);
    endtask

    // Launch one burst (called at a falling edge) and check it against the model.
    task automatic run_burst(input logic [AW-1:0] st, input logic [2:0] code,
                             input bit lin_in, input int lat, input int maxw);
        int L, D, W, k;
        bit cont, lin, crossed, done, last;
        logic [AW-1:0] a;
        logic [3:0] mask;
        string dtag;
        start_i = 1'b1; start_addr_i = st; len_code_i = code;
        linear_i = lin_in; latency_i = LW'(lat);
        @(negedge clk);
        start_i = 1'b0;
        // R8: scramble configuration after the capture
        start_addr_i = ~st; len_code_i = 3'b000; linear_i = ~lin_in; latency_i = '0;
        L    = (lat == 0) ? 1 : lat;
        D    = (st[1:0] == 2'd0) ? 0 : ((L + st[1:0] > 4) ? L + st[1:0] - 4 : 0);
        cont = (code == 3'b111);
        W    = (code == 3'b001) ? 4 : (code == 3'b010) ? 8 : 16;
        mask = 4'(W - 1);
        lin  = lin_in || cont;
        dtag = cont ? "R6" : (lin ? "R4" : "R5");
        for (int j = 0; j < L; j++) expect_cyc(1'b0, 1'b1, '0, 1'b0, "R2");
        a = st; k = 0; crossed = 1'b0; done = 1'b0;
        while (!done && k < maxw) begin
            expect_cyc(1'b1, 1'b0, a, 1'b1, (k == 0) ? "R2" : dtag);
            k++;
            last = cont ? (a == {AW{1'b1}}) : (k == W);
            if (last) done = 1'b1;
            else begin
                if (lin && a[3:0] == 4'hF && !crossed) begin
                    crossed = 1'b1;
                    for (int s = 0; s < D; s++) expect_cyc(1'b0, 1'b1, '0, 1'b0, "R7");
                end
                if (lin) a = a + 1'b1;
                else     a = {a[AW-1:4], (a[3:0] & ~mask) | ((a[3:0] + 4'd1) & mask)};
            end
        end
        if (done) begin
            expect_cyc(1'b0, 1'b0, '0, 1'b0, cont ? "R6" : "R3");
            expect_cyc(1'b0, 1'b0, '0, 1'b0, cont ? "R6" : "R3");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] codes [4];
        int lats [4];
        codes[0] = 3'b001; codes[1] = 3'b010; codes[2] = 3'b011; codes[3] = 3'b111;
        lats[0] = 1; lats[1] = 2; lats[2] = 4; lats[3] = 6;

        // R1: reset state, during and after reset
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/4);
        chk(word_valid_o == 0 && hold_o == 0 && addr_o == 0, "R1",
            {word_valid_o, hold_o, addr_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #(CLK_PERIOD/4);
        chk(word_valid_o == 0 && hold_o == 0 && addr_o == 0, "R1",
            {word_valid_o, hold_o, addr_o}, 0);
        @(negedge clk);

        // Listed examples: start 5 wrap 4 words, start 14 linear 16 words
        run_burst(8'd5, 3'b001, 1'b0, 2, 16);
        run_burst(8'd14, 3'b011, 1'b1, 1, 16);

        // R3 R4 R5 R6 R7: sweep starts, codes, wrap and latencies
        for (int s = 0; s < 32; s++)
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 2; w++)
                    for (int l = 0; l < 4; l++)
                        run_burst(AW'(s), codes[c], w[0], lats[l], 40);

        // R4: linear rollover at the top of the space
        run_burst(8'd250, 3'b011, 1'b1, 3, 16);
        run_burst(8'd254, 3'b010, 1'b1, 5, 16);
        // R6: continuous stops at all ones, wrap bit ignored
        run_burst(8'd243, 3'b111, 1'b0, 3, 40);
        // R2: latency 0 behaves as 1
        run_burst(8'd7, 3'b010, 1'b1, 0, 16);

        // R8: abort a continuous burst with a new start
        run_burst(8'd100, 3'b111, 1'b1, 1, 5);
        run_burst(8'd33, 3'b001, 1'b0, 2, 16);

        // R9: reserved code ends a running burst
        run_burst(8'd60, 3'b111, 1'b1, 1, 4);
        start_i = 1'b1; len_code_i = 3'b100; start_addr_i = 8'd3; latency_i = 4'd2;
        @(negedge clk);
        start_i = 1'b0;
        for (int j = 0; j < 3; j++) expect_cyc(1'b0, 1'b0, '0, 1'b0, "R9");

        // R10: rising mode shows hold a quarter period after the capture edge
        start_i = 1'b1; len_code_i = 3'b001; start_addr_i = 8'd8;
        linear_i = 1'b1; latency_i = 4'd3; negedge_sel_i = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(hold_o == 1'b1, "R10", hold_o, 1);
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        // R10: falling mode shows it only after the falling edge
        negedge_sel_i = 1'b1;
        start_i = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(hold_o == 1'b0, "R10", hold_o, 0);
        @(negedge clk);
        start_i = 1'b0;
        #(CLK_PERIOD/4);
        chk(hold_o == 1'b1, "R10", hold_o, 1);
        repeat (10) @(negedge clk);
        // R10: full bursts in falling mode match the same model
        run_burst(8'd13, 3'b011, 1'b1, 4, 16);
        run_burst(8'd6, 3'b010, 1'b0, 2, 16);
        negedge_sel_i = 1'b0;
        run_burst(8'd3, 3'b011, 1'b1, 6, 16);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule